// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical frame number by reading two page-table entries from an external memory, one after the other. The 20-bit page number above the 12-bit page offset is split into two 10-bit indexes. The upper index selects an entry in the top-level table, whose base frame is given on an input. That entry, if marked valid, gives the base frame of a second-level table. The lower index then selects an entry in that second table, and that entry gives the frame number.

A requester presents a virtual address and a root frame while the walker signals ready. A few cycles later the walker pulses either a completion strobe with the frame number or a fault strobe. The walker has one memory port that allows one outstanding read: it issues a read strobe with a byte address and waits for a single response word. The result is meant to refill a translation buffer, so the walker does no caching of its own.

Top module: `pt_walker`

## Requirements
- R1: `reqReady` is high only while the walker is idle. A request is taken at a rising edge where `reqValid` and `reqReady` are both high, and `reqReady` is low in the next cycle. A `reqValid` seen while `reqReady` is low is ignored.
- R2: In the cycle after a request is taken, `memReqValid` is high for one cycle. In that cycle `memReqAddr` = {`rootFrame`, `reqVaddr[31:22]`, 2'b00}.
- R3: When the first response has bit 0 set, the walker issues a second read in the cycle after that response. Its address is {first response bits [31:12], `reqVaddr[21:12]`, 2'b00}.
- R4: When the second response has bit 0 set, `doneValid` pulses for exactly one cycle, starting one cycle after that response. During the pulse `doneFrame` equals bits [31:12] of that response.
- R5: When the first response has bit 0 clear, `doneFault` pulses for one cycle, starting one cycle after that response. No second read is issued and `doneValid` stays low.
- R6: When the second response has bit 0 clear, `doneFault` pulses for one cycle, starting one cycle after that response, and `doneValid` stays low.
- R7: A walk issues at most one read at a time: two reads when the first entry is valid, otherwise one. No new read is issued until the previous one has been answered.
- R8: A `memRspValid` that arrives while no read is outstanding has no effect. No done or fault strobe follows it, no read follows it, and `reqReady` stays high.
- R9: After reset `reqReady` is high, and `memReqValid`, `doneValid`, `doneFault` and `doneFrame` are all zero.
- R10: `doneFrame` is zero whenever `doneValid` is low.
- R11: `reqVaddr` and `rootFrame` are sampled only when a request is taken. Changing them during a walk does not change its reads or its result.
- R12: After a done or fault pulse, the walker is ready again in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Walk request strobe |
| reqVaddr | input | 32 | Virtual address to translate |
| rootFrame | input | 20 | Frame number of the top-level table |
| reqReady | output | 1 | Walker idle and able to take a request |
| memReqValid | output | 1 | One-cycle memory read strobe |
| memReqAddr | output | 32 | Byte address of the entry to read |
| memRspValid | input | 1 | Read data valid, one cycle |
| memRspData | input | 32 | Page-table entry read from memory |
| doneValid | output | 1 | One-cycle success pulse |
| doneFault | output | 1 | One-cycle fault pulse |
| doneFrame | output | 20 | Resolved frame number, zero outside `doneValid` |

## Verification
The assertions take it for granted that the memory answers each read strobe with exactly one response, that the response comes no earlier than the cycle in which the strobe is visible, and that no response that could be confused with a real answer arrives while a read is outstanding. The bench memory model follows this. It answers each read once, after a latency chosen per walk between zero and three cycles. It injects unsolicited responses only while the walker holds no outstanding read. Entry contents come from an arithmetic function of the address, and bits [4:2] equal to 7 mark an entry invalid, so the sweep reaches both fault levels.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_READ_L1 = 2'd1,
    ST_READ_L2 = 2'd2,
    ST_DONE    = 2'd3
  } walkState_t;

  // strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic accept;      // latch request, issue first read
    logic issueL2;     // issue second read from the response
    logic finishOk;    // publish frame from the response
    logic finishFault; // publish fault
  } walkCtl_t;

endpackage

// File: rtl/pt_walker_ctrl.sv
module pt_walker_ctrl
  import pt_walker_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     memRspValid,
  input  logic     rspEntryValid,
  output logic     reqReady,
  output walkCtl_t ctl
);

  walkState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    ctl       = '0;
    stateNext = state;
    reqReady  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          ctl.accept = 1'b1;
          stateNext  = ST_READ_L1;
        end
      end
      ST_READ_L1: begin
        if (memRspValid) begin
          if (rspEntryValid) begin
            ctl.issueL2 = 1'b1;
            stateNext   = ST_READ_L2;
          end else begin
            ctl.finishFault = 1'b1;
            stateNext       = ST_DONE;
          end
        end
      end
      ST_READ_L2: begin
        if (memRspValid) begin
          ctl.finishOk    = rspEntryValid;
          ctl.finishFault = !rspEntryValid;
          stateNext       = ST_DONE;
        end
      end
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/pt_walker_dp.sv
module pt_walker_dp
  import pt_walker_pkg::*;
#(
  parameter int VA_W   = 32,
  parameter int PAGE_W = 12,
  parameter int PTE_W  = 32
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  walkCtl_t                  ctl,
  input  logic [VA_W-1:0]           reqVaddr,
  input  logic [PTE_W-PAGE_W-1:0]   rootFrame,
  input  logic [PTE_W-1:0]          memRspData,
  output logic                      rspEntryValid,
  output logic                      memReqValid,
  output logic [PTE_W-1:0]          memReqAddr,
  output logic                      doneValid,
  output logic                      doneFault,
  output logic [PTE_W-PAGE_W-1:0]   doneFrame
);

  localparam int VPN_W       = VA_W - PAGE_W;
  localparam int IDX_W       = VPN_W / 2;
  localparam int FRAME_W     = PTE_W - PAGE_W;
  localparam int ENTRY_SHIFT = $clog2(PTE_W / 8);

  logic [IDX_W-1:0]   innerIdx;
  logic [IDX_W-1:0]   outerIdxIn;
  logic [IDX_W-1:0]   innerIdxIn;
  logic [FRAME_W-1:0] rspFrame;
  logic               dpUnused;

  assign outerIdxIn    = reqVaddr[VA_W-1 -: IDX_W];
  assign innerIdxIn    = reqVaddr[PAGE_W +: IDX_W];
  assign rspFrame      = memRspData[PTE_W-1:PAGE_W];
  assign rspEntryValid = memRspData[0];
  assign dpUnused      = ^{reqVaddr[PAGE_W-1:0], memRspData[PAGE_W-1:1]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      innerIdx    <= '0;
      memReqValid <= 1'b0;
      memReqAddr  <= '0;
      doneValid   <= 1'b0;
      doneFault   <= 1'b0;
      doneFrame   <= '0;
    end else begin
      memReqValid <= ctl.accept | ctl.issueL2;
      doneValid   <= ctl.finishOk;
      doneFault   <= ctl.finishFault;
      doneFrame   <= ctl.finishOk ? rspFrame : '0;
      if (ctl.accept) begin
        innerIdx   <= innerIdxIn;
        memReqAddr <= {rootFrame, outerIdxIn, {ENTRY_SHIFT{1'b0}}};
      end else if (ctl.issueL2) begin
        memReqAddr <= {rspFrame, innerIdx, {ENTRY_SHIFT{1'b0}}};
      end
    end
  end

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int VA_W   = 32,
  parameter int PAGE_W = 12,
  parameter int PTE_W  = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  input  logic [VA_W-1:0]         reqVaddr,
  input  logic [PTE_W-PAGE_W-1:0] rootFrame,
  output logic                    reqReady,
  output logic                    memReqValid,
  output logic [PTE_W-1:0]        memReqAddr,
  input  logic                    memRspValid,
  input  logic [PTE_W-1:0]        memRspData,
  output logic                    doneValid,
  output logic                    doneFault,
  output logic [PTE_W-PAGE_W-1:0] doneFrame
);

  walkCtl_t ctl;
  logic     rspEntryValid;

  pt_walker_ctrl u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .reqValid      (reqValid),
    .memRspValid   (memRspValid),
    .rspEntryValid (rspEntryValid),
    .reqReady      (reqReady),
    .ctl           (ctl)
  );

  pt_walker_dp #(
    .VA_W   (VA_W),
    .PAGE_W (PAGE_W),
    .PTE_W  (PTE_W)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .ctl           (ctl),
    .reqVaddr      (reqVaddr),
    .rootFrame     (rootFrame),
    .memRspData    (memRspData),
    .rspEntryValid (rspEntryValid),
    .memReqValid   (memReqValid),
    .memReqAddr    (memReqAddr),
    .doneValid     (doneValid),
    .doneFault     (doneFault),
    .doneFrame     (doneFrame)
  );

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int VA_W   = 32,
  parameter int PAGE_W = 12,
  parameter int PTE_W  = 32
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    reqValid,
  input logic [VA_W-1:0]         reqVaddr,
  input logic [PTE_W-PAGE_W-1:0] rootFrame,
  input logic                    reqReady,
  input logic                    memReqValid,
  input logic [PTE_W-1:0]        memReqAddr,
  input logic                    memRspValid,
  input logic [PTE_W-1:0]        memRspData,
  input logic                    doneValid,
  input logic                    doneFault,
  input logic [PTE_W-PAGE_W-1:0] doneFrame
);

  localparam int IDX_W       = (VA_W - PAGE_W) / 2;
  localparam int ENTRY_SHIFT = $clog2(PTE_W / 8);

  logic             outstanding;
  logic             pending;
  logic             firstSeen;
  logic [IDX_W-1:0] innerHold;
  logic             ckUnused;

  assign pending  = outstanding | memReqValid;
  assign ckUnused = ^{reqVaddr[PAGE_W-1:0], memRspData[PAGE_W-1:1]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outstanding <= 1'b0;
      firstSeen   <= 1'b0;
      innerHold   <= '0;
    end else begin
      if (memRspValid && pending) outstanding <= 1'b0;
      else if (memReqValid)       outstanding <= 1'b1;
      if (reqValid && reqReady) begin
        firstSeen <= 1'b0;
        innerHold <= reqVaddr[PAGE_W +: IDX_W];
      end else if (memReqValid) begin
        firstSeen <= 1'b1;
      end
    end
  end

  a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  a_r2_l1_address: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (memReqValid &&
      memReqAddr == {$past(rootFrame), $past(reqVaddr[VA_W-1 -: IDX_W]), {ENTRY_SHIFT{1'b0}}}));

  a_r3_l2_address: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && firstSeen) |->
      (memReqAddr == {$past(memRspData[PTE_W-1:PAGE_W]), innerHold, {ENTRY_SHIFT{1'b0}}}));

  a_r4_done_frame: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> ($past(memRspValid) && $past(memRspData[0]) &&
                   doneFrame == $past(memRspData[PTE_W-1:PAGE_W])));

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  a_r5_fault_stops_walk: assert property (@(posedge clk) disable iff (!rstN)
    (pending && memRspValid && !memRspData[0]) |=> (doneFault && !doneValid && !memReqValid));

  a_r7_one_outstanding: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> !outstanding);

  a_r10_frame_zero: assert property (@(posedge clk) disable iff (!rstN)
    !doneValid |-> (doneFrame == '0));

  a_r12_ready_after_end: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid || doneFault) |=> reqReady);

endmodule

bind pt_walker pt_walker_chk #(
  .VA_W   (VA_W),
  .PAGE_W (PAGE_W),
  .PTE_W  (PTE_W)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .reqValid    (reqValid),
  .reqVaddr    (reqVaddr),
  .rootFrame   (rootFrame),
  .reqReady    (reqReady),
  .memReqValid (memReqValid),
  .memReqAddr  (memReqAddr),
  .memRspValid (memRspValid),
  .memRspData  (memRspData),
  .doneValid   (doneValid),
  .doneFault   (doneFault),
  .doneFrame   (doneFrame)
);

// File: tb/pt_walker_bench.sv
`timescale 1ns/1ps
module pt_walker_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqVaddr = '0;
  logic [19:0] rootFrame = '0;
  logic        reqReady;
  logic        memReqValid;
  logic [31:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = '0;
  logic        doneValid;
  logic        doneFault;
  logic [19:0] doneFrame;

  int vectors = 0;
  int fails = 0;
  int cyc = 0;
  int memLat = 0;
  bit strayOn = 1'b0;
  int readCount = 0;
  int rspCycle = 0;
  logic [31:0] rdAddr [2];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pt_walker u_pt_walker (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVaddr(reqVaddr),
    .rootFrame(rootFrame), .reqReady(reqReady), .memReqValid(memReqValid),
    .memReqAddr(memReqAddr), .memRspValid(memRspValid), .memRspData(memRspData),
    .doneValid(doneValid), .doneFault(doneFault), .doneFrame(doneFrame)
  );

  // entry content: frame from a hash of the address, invalid when addr[4:2]==7
  function automatic logic [31:0] memf(input logic [31:0] a);
    logic [19:0] h;
    h = a[31:12] ^ (a[21:2] * 20'd40503) ^ 20'h5A5A5;
    return {h, 11'd0, (a[4:2] != 3'd7)};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model: one response per read after memLat cycles
  initial begin
    forever begin
      @(negedge clk);
      memRspValid = 1'b0;
      if (memReqValid) begin
        logic [31:0] a;
        a = memReqAddr;
        if (readCount < 2) rdAddr[readCount] = a;
        readCount++;
        repeat (memLat) @(negedge clk);
        memRspData  = memf(a);
        memRspValid = 1'b1;
        rspCycle    = cyc;
      end else if (strayOn) begin
        memRspData  = memf(32'(cyc * 4));
        memRspValid = 1'b1;
      end
    end
  end

  task automatic doWalk(input logic [31:0] va, input logic [19:0] root, input int lat, input bit stray);
    logic [31:0] l1, l2, e1, e2;
    bit expFault;
    int expReads;
    logic [19:0] expFrame;
    int t;
    l1 = {root, va[31:22], 2'b00};
    e1 = memf(l1);
    l2 = {e1[31:12], va[21:12], 2'b00};
    e2 = memf(l2);
    if (!e1[0]) begin expFault = 1; expReads = 1; expFrame = '0; end
    else begin expFault = !e2[0]; expReads = 2; expFrame = e2[0] ? e2[31:12] : 20'd0; end

    memLat = lat;
    readCount = 0;
    @(negedge clk);
    reqValid = 1'b1; reqVaddr = va; rootFrame = root;
    @(negedge clk);
    chk(memReqValid == 1'b1, "R2 first read strobe", 32'(memReqValid), 32'd1);
    chk(reqReady == 1'b0, "R1 busy after accept", 32'(reqReady), 32'd0);
    // junk request held during the walk (R1 ignored, R11 no effect)
    reqVaddr = ~va; rootFrame = ~root;
    t = 0;
    while (!(doneValid || doneFault) && t < 60) begin
      @(negedge clk);
      t++;
    end
    reqValid = 1'b0;
    chk(t < 60, "R4 walk completes", 32'(t), 32'd60);
    chk(readCount == expReads, "R7 read count", 32'(readCount), 32'(expReads));
    chk(rdAddr[0] == l1, "R2 first read address", rdAddr[0], l1);
    if (expReads == 2)
      chk(rdAddr[1] == l2, "R3 second read address", rdAddr[1], l2);
    chk(doneFault == expFault, expReads == 1 ? "R5 fault level one" : "R6 fault level two",
        32'(doneFault), 32'(expFault));
    chk(doneValid == !expFault, "R4 done strobe", 32'(doneValid), 32'(!expFault));
    chk(doneFrame == expFrame, "R4 R10 frame", 32'(doneFrame), 32'(expFrame));
    chk(cyc == rspCycle + 1, "R4 latency after response", 32'(cyc), 32'(rspCycle + 1));
    @(negedge clk);
    chk(reqReady == 1'b1, "R12 ready after end", 32'(reqReady), 32'd1);
    chk(!doneValid && !doneFault, "R4 one-cycle pulse", {30'd0, doneValid, doneFault}, 32'd0);
    chk(memReqValid == 1'b0, "R1 busy request not taken", 32'(memReqValid), 32'd0);
    chk(doneFrame == 20'd0, "R10 frame zero", 32'(doneFrame), 32'd0);
    if (stray) begin
      strayOn = 1'b1;
      repeat (4) begin
        @(negedge clk);
        chk(!doneValid && !doneFault && !memReqValid && reqReady, "R8 stray response",
            {28'd0, doneValid, doneFault, memReqValid, reqReady}, 32'd1);
      end
      strayOn = 1'b0;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(reqReady == 1'b1, "R9 reset ready", 32'(reqReady), 32'd1);
    chk(!memReqValid && !doneValid && !doneFault, "R9 reset strobes",
        {29'd0, memReqValid, doneValid, doneFault}, 32'd0);
    chk(doneFrame == 20'd0, "R9 reset frame", 32'(doneFrame), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady == 1'b1, "R9 ready after reset release", 32'(reqReady), 32'd1);

    doWalk(32'h1234_5678, 20'hABCDE, 0, 1'b1); // R4 success
    doWalk(32'h01C0_0000, 20'h00400, 2, 1'b0); // R5 level-one fault
    doWalk(32'h0000_7000, 20'h00400, 1, 1'b0); // R6 level-two fault
    doWalk(32'hFFFF_FFFF, 20'hFFFFF, 3, 1'b1); // top corner
    doWalk(32'h0000_0000, 20'h00000, 0, 1'b0); // bottom corner

    for (int o = 0; o < 1024; o++) begin
      int inner;
      logic [31:0] va;
      inner = (o * 37 + 5) % 1024;
      va = {o[9:0], inner[9:0], 12'(o * 13)};
      doWalk(va, (o < 512) ? 20'hABCDE : 20'h00013, o % 4, (o % 5) == 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(150000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule